// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a watchdog for an embedded processor core. It counts cycles of a time-base tick enable and, each time a period chosen from four powers of two runs out, moves a two-bit escalation state kept in the top of its status register. The first expiry arms the next stage. The second expiry can raise an interrupt. The third expiry stops the watchdog, copies the configured reset type into the status register and, when that type is non-zero, issues a one-cycle reset request that carries the type.

Software configures the period, the reset type and the interrupt enable through a control register. It services the watchdog by writing ones to the escalation bits of the status register. This clears those bits and starts the period again from zero. The reset request goes to a separate reset controller that lies outside this block.

Top module: `wdog_escalator`

## Requirements
- R1: After reset, both register readbacks are zero, `irq` and `rst_req` are low and `rst_type` is 00.
- R2: Control bits 31:30 (value p) set the period to 2^(BASE+p*STEP) tick-enabled cycles. Cycles with `tick` low do not advance the count. With the defaults, the periods are 2^17, 2^21, 2^25 and 2^29.
- R3: At an expiry in escalation state 00 or 01 (status bits 31:30), status bit 31 is set and the period restarts.
- R4: At an expiry in state 10, status bit 30 is set and the period restarts. `irq` is high whenever status bit 30 and control bit 27 are both 1, and low otherwise.
- R5: At an expiry in state 11, control bits 29:28 are copied into status bits 29:28 and the count stops. No later tick changes the count or the status until the next service write.
- R6: At that final expiry, a non-zero reset type produces `rst_req` high for exactly one cycle, with `rst_type` equal to the type (01 core, 10 chip, 11 system). Type 00 produces no request.
- R7: A status write (`wr_sel`=1) clears each of status bits 31:28 whose data bit is 1. Setting data bit 31 or 30 also restarts the period from zero and resumes counting.
- R8: A control write (`wr_sel`=0) stores data bits 31:27. All other bits of both readbacks are always zero.
- R9: When a service write and an expiry fall in the same cycle, the write wins. The expiry is discarded and the period restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 32 | Write data |
| rd_ctrl | output | 32 | Control register readback |
| rd_stat | output | 32 | Status register readback |
| irq | output | 1 | Watchdog interrupt level |
| rst_req | output | 1 | One-cycle reset request |
| rst_type | output | 2 | Type of the last reset request |

## Verification
A service write and a period expiry can land in the same clock cycle, and the block must then treat the servicing as the only event. The bench lets the count reach one tick short of expiry. It then drives the final tick together with a status write of bit 31. It expects the escalation bits to remain clear and the next expiry to come one full period after that cycle. The sweep over all periods, reset types and tick spacings checks the state, `irq` and `rst_req` against a tick count computed arithmetically after every tick.

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int BASE = 17,
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_ctrl,
  output logic [31:0] rd_stat,
  output logic        irq,
  output logic        rst_req,
  output logic [1:0]  rst_type
);
  localparam int CW = BASE + 3 * STEP;

  // ctrl_q = control[31:27], stat_q = status[31:28]
  logic [4:0]    ctrl_q;
  logic [3:0]    stat_q;
  logic [CW-1:0] cnt_q;
  logic          halt_q;
  logic          req_q;
  logic [1:0]    type_q;
  logic [CW:0]   lim_m1;
  logic [3:0]    clr;
  logic          svc, expire;

  always_comb lim_m1 = ((CW+1)'(1) << (BASE + int'(ctrl_q[4:3]) * STEP)) - (CW+1)'(1);

  assign clr    = (wr_en && wr_sel) ? wr_data[31:28] : 4'b0000;
  assign svc    = clr[3] | clr[2];
  assign expire = tick && !halt_q && ({1'b0, cnt_q} >= lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
      halt_q <= 1'b0;
      req_q  <= 1'b0;
      type_q <= 2'b00;
    end else begin
      req_q <= 1'b0;
      if (wr_en && !wr_sel) ctrl_q <= wr_data[31:27];
      if (svc) begin
        stat_q <= stat_q & ~clr;
        cnt_q  <= '0;
        halt_q <= 1'b0;
      end else if (expire) begin
        cnt_q <= '0;
        unique case (stat_q[3:2])
          2'b00, 2'b01: stat_q <= (stat_q | 4'b1000) & ~clr;
          2'b10:        stat_q <= (stat_q | 4'b0100) & ~clr;
          default: begin
            stat_q <= {2'b11, ctrl_q[2:1] & ~clr[1:0]};
            halt_q <= 1'b1;
            if (ctrl_q[2:1] != 2'b00) begin
              req_q  <= 1'b1;
              type_q <= ctrl_q[2:1];
            end
          end
        endcase
      end else begin
        stat_q <= stat_q & ~clr;
        if (tick && !halt_q) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rd_ctrl  = {ctrl_q, 27'd0};
  assign rd_stat  = {stat_q, 28'd0};
  assign irq      = stat_q[2] & ctrl_q[0];
  assign rst_req  = req_q;
  assign rst_type = type_q;

  assert_req_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rst_type != 2'b00);
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_req_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(stat_q[3:2]) == 2'b11);
  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !(wr_en && wr_sel)) |=> ($stable(cnt_q) && $stable(stat_q)));
  assert_no_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3:2] == 2'b00) |=> (stat_q[3:2] != 2'b11));
endmodule

// File: tb/sim_wdog_escalator.sv
module sim_wdog_escalator;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;
  localparam int STEP = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_ctrl, rd_stat;
  logic        irq, rst_req;
  logic [1:0]  rst_type;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_escalator #(.BASE(BASE), .STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_ctrl(rd_ctrl), .rd_stat(rd_stat), .irq(irq),
    .rst_req(rst_req), .rst_type(rst_type));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic one_tick(input int gap);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int g = 1; g < gap; g++) begin
      if (g == 1) chk("R6 pulse width", {31'd0, rst_req}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int p, input int ty, input int gap);
    int len, e;
    logic ien;
    len = 1 << (BASE + p * STEP);
    ien = ty[0];
    wr(1'b0, {p[1:0], ty[1:0], ien, 27'h7FFFFFF});
    wr(1'b1, 32'hF000_0000);
    chk("R7 cleared", rd_stat, 32'd0);
    for (int n = 1; n <= 3 * len + 3; n++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      e = (n / len > 3) ? 3 : n / len;
      chk("R2 R3 R4 R5 state", rd_stat,
          {(e >= 1), (e >= 2), (e >= 3) ? ty[1:0] : 2'b00, 28'd0});
      chk("R4 irq", {31'd0, irq}, {31'd0, (e >= 2) && ien});
      chk("R6 request", {31'd0, rst_req}, {31'd0, (n == 3 * len) && (ty != 0)});
      if (n == 3 * len && ty != 0) chk("R6 type", {30'd0, rst_type}, ty);
      for (int g = 1; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl", rd_ctrl, 0);
    chk("R1 stat", rd_stat, 0);
    chk("R1 outs", {29'd0, irq, rst_req, rst_type == 2'b00}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    wr(1'b0, 32'hFFFF_FFFF);
    chk("R8 ctrl mask", rd_ctrl, 32'hF800_0000);
    wr(1'b1, 32'h0FFF_FFFF);
    chk("R8 stat mask", rd_stat, 32'd0);
    for (int p = 0; p < 4; p++)
      for (int ty = 0; ty < 4; ty++)
        run_case(p, ty, 1 + (p + ty) % 3);
    // R4: irq follows the enable bit while bit 30 is set
    wr(1'b0, 32'h3000_0000);
    chk("R4 irq off", {31'd0, irq}, 32'd0);
    wr(1'b0, 32'h3800_0000);
    chk("R4 irq on", {31'd0, irq}, 32'd1);
    // R7: clearing only bits 29:28 keeps escalation state and halt
    wr(1'b1, 32'h3000_0000);
    chk("R7 partial", rd_stat, 32'hC000_0000);
    one_tick(2);
    chk("R5 still halted", rd_stat, 32'hC000_0000);
    // R9: service and expiry in the same cycle; period 4
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, 32'hF000_0000);
    for (int k = 0; k < 3; k++) one_tick(1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h8000_0000;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R9 expiry dropped", rd_stat, 32'd0);
    for (int k = 0; k < 3; k++) one_tick(1);
    chk("R9 restarted", rd_stat, 32'd0);
    one_tick(1);
    chk("R9 next expiry", rd_stat, 32'h8000_0000);
    // R7: service from state 10 restarts the count
    for (int k = 0; k < 2; k++) one_tick(1);
    wr(1'b1, 32'h8000_0000);
    for (int k = 0; k < 3; k++) one_tick(1);
    chk("R7 restart", rd_stat, 32'd0);
    one_tick(1);
    chk("R7 expiry after", rd_stat, 32'h8000_0000);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule